// File: doc/BRIEF.md
# Frame Engine Launch and Interrupt Control

This block is the software-facing control layer of a frame-processing accelerator. Software writes a control word to launch the datapath for one frame. It can also switch the engine into a free-running mode, ask for the memory side to be drained, and poll the progress bits. In return the block gives the datapath a one-cycle launch pulse. It takes back a completion pulse and a ready-for-input pulse from the datapath.

Both returned events are latched in an interrupt status register. A per-source enable and a global gate decide whether the latched events raise the single interrupt line. Status bits are cleared by writing ones to them. A plain single-cycle register port with a write strobe and a read strobe replaces the usual memory-mapped bus. Read data comes back one cycle after the read strobe.

Top module: `scd_ctrl_regs`

Register offsets (byte addresses on `reg_addr`): control 0x0, global enable 0x4, source enable 0x8, status 0xC.

Control word bit positions:

| Bit | Name | Behaviour |
|---|---|---|
| 0 | start | Writing 1 launches a frame. Reads 1 while a frame is in progress. |
| 1 | done | Set when a frame finishes. Cleared on read. |
| 2 | idle | Reads 1 when no frame is in progress. |
| 3 | ready | Set by the datapath's ready pulse. |
| 5 | flush request | Write 1 to set. Stays set until reset. |
| 6 | flush done | Set once the flush has drained. |
| 7 | free-run | When set, the engine relaunches itself after each frame. |

Source numbering in the enable and status registers is the same: bit 0 is completion and bit 1 is ready.

## Requirements
- R1: After reset the control word reads 0x4 (only idle set), and the global enable, source enable and status registers read 0. `irq`, `eng_start` and `flush_req` are low.
- R2: Writing the control word with bit 0 set while idle produces exactly one `eng_start` pulse, in the cycle after the write. The control word then reads with bit 0 = 1 and bit 2 = 0 until the frame ends.
- R3: A start write while a frame is in progress is ignored: no `eng_start` pulse follows.
- R4: An `eng_done` pulse during a frame ends it: idle (bit 2) and done (bit 1) are set. A read of the control word returns done = 1 and clears it, so the next read returns done = 0. An `eng_done` pulse while idle is ignored and sets neither done nor status bit 0.
- R5: With free-run (bit 7) set, each `eng_done` produces a new `eng_start` pulse in the next cycle and the engine stays busy. Bit 7 reads back as written. Clearing it stops the relaunch.
- R6: An `eng_ready` pulse sets control bit 3. A start accepted later clears bit 3.
- R7: Writing 1 to bit 5 raises `flush_req` and control bit 5. Later writes of 0 do not clear either. Control bit 6 is set once `flush_drained` is high while a flush is requested, and never without a request.
- R8: Status bit 0 latches accepted completions and bit 1 latches ready pulses. Writing 1 to a status bit clears it and writing 0 leaves it. An event arriving in the same cycle as its clearing write leaves the bit set.
- R9: `irq` equals global enable bit 0 AND the OR over sources of (source enable AND status), one cycle after those registers change. With the global enable at 0, `irq` stays low.
- R10: Reserved bits read as 0, writes to them have no effect, and an offset other than the four mapped ones reads 0.
- R11: `reg_rdata` is updated only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| eng_start | output | 1 | One-cycle frame launch pulse to the datapath |
| eng_done | input | 1 | Frame completion pulse from the datapath |
| eng_ready | input | 1 | Datapath ready-for-input pulse |
| flush_req | output | 1 | Flush request level to the memory side |
| flush_drained | input | 1 | High when outstanding memory transactions have drained |
| irq | output | 1 | Registered interrupt output |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle and that each datapath event is a one-cycle pulse. They do not rely on `eng_done` arriving only while a frame is in progress; that case is defined as ignored.

The stimulus drives every input on the falling clock edge and releases every strobe after one cycle. It only issues completion pulses at least one cycle after the matching launch. The one deliberate overlap is a status-clearing write landing in the same cycle as a completion event; it exercises R8's rule that the event takes priority.

// File: rtl/scd_ctrl_pkg.sv
package scd_ctrl_pkg;
  // register byte offsets
  localparam int OFS_CTRL = 'h0;
  localparam int OFS_GIE  = 'h4;
  localparam int OFS_IER  = 'h8;
  localparam int OFS_ISR  = 'hC;

  // control word bit positions
  localparam int CB_START  = 0;
  localparam int CB_DONE   = 1;
  localparam int CB_IDLE   = 2;
  localparam int CB_READY  = 3;
  localparam int CB_FLREQ  = 5;
  localparam int CB_FLDONE = 6;
  localparam int CB_AUTO   = 7;
  localparam int CTRL_USED = 8;

  // interrupt sources
  localparam int SRC_DONE  = 0;
  localparam int SRC_READY = 1;
  localparam int N_SRC     = 2;

  typedef struct packed {
    logic auto_rs;
    logic fl_done;
    logic fl_req;
    logic rsvd4;
    logic ready;
    logic idle;
    logic done;
    logic start;
  } ctrl_view_t;
endpackage

// File: rtl/scd_reg_if.sv
module scd_reg_if
  import scd_ctrl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  ctrl_view_t        ctrl_word,
  input  logic              gie,
  input  logic [N_SRC-1:0]  ier,
  input  logic [N_SRC-1:0]  isr,
  output logic              wr_ctrl,
  output logic              wr_gie,
  output logic              wr_ier,
  output logic              wr_isr,
  output logic              rd_ctrl,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_CTRL = DATA_W - CTRL_USED;
  localparam int PAD_SRC  = DATA_W - N_SRC;

  logic hit_ctrl, hit_gie, hit_ier, hit_isr;

  assign hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
  assign hit_gie  = (reg_addr == ADDR_W'(OFS_GIE));
  assign hit_ier  = (reg_addr == ADDR_W'(OFS_IER));
  assign hit_isr  = (reg_addr == ADDR_W'(OFS_ISR));

  assign wr_ctrl = reg_wr & hit_ctrl;
  assign wr_gie  = reg_wr & hit_gie;
  assign wr_ier  = reg_wr & hit_ier;
  assign wr_isr  = reg_wr & hit_isr;
  assign rd_ctrl = reg_rd & hit_ctrl;

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)     rd_mux = {{PAD_CTRL{1'b0}}, ctrl_word};
    else if (hit_gie) rd_mux = {{(DATA_W-1){1'b0}}, gie};
    else if (hit_ier) rd_mux = {{PAD_SRC{1'b0}}, ier};
    else if (hit_isr) rd_mux = {{PAD_SRC{1'b0}}, isr};
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (reg_rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/scd_run_ctrl.sv
module scd_run_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_ctrl,
  input  logic rd_ctrl,
  input  logic w_start,
  input  logic w_flreq,
  input  logic w_auto,
  input  logic eng_done,
  input  logic eng_ready,
  input  logic flush_drained,
  output logic eng_start,
  output logic busy,
  output logic done_q,
  output logic ready_q,
  output logic auto_q,
  output logic flreq_q,
  output logic fldone_q,
  output logic done_evt
);
  logic start_acc;
  logic relaunch;

  // a completion only counts while a frame is running
  assign done_evt  = eng_done & busy;
  assign start_acc = wr_ctrl & w_start & ~busy;
  assign relaunch  = done_evt & auto_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      eng_start <= start_acc | relaunch;
      if (start_acc)     busy <= 1'b1;
      else if (done_evt) busy <= auto_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           done_q <= 1'b0;
    else if (done_evt) done_q <= 1'b1;
    else if (rd_ctrl)  done_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            ready_q <= 1'b0;
    else if (eng_ready) ready_q <= 1'b1;
    else if (start_acc) ready_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          auto_q <= 1'b0;
    else if (wr_ctrl) auto_q <= w_auto;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flreq_q  <= 1'b0;
      fldone_q <= 1'b0;
    end else begin
      if (wr_ctrl && w_flreq)       flreq_q  <= 1'b1;
      if (flreq_q && flush_drained) fldone_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scd_irq_unit.sv
module scd_irq_unit #(
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_gie,
  input  logic          wr_ier,
  input  logic          wr_isr,
  input  logic          w_gie,
  input  logic [NS-1:0] w_bits,
  input  logic [NS-1:0] evt,
  output logic          gie_q,
  output logic [NS-1:0] ier_q,
  output logic [NS-1:0] isr_q,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst)         gie_q <= 1'b0;
    else if (wr_gie) gie_q <= w_gie;
  end

  for (genvar s = 0; s < NS; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)         ier_q[s] <= 1'b0;
      else if (wr_ier) ier_q[s] <= w_bits[s];
    end

    // a new event takes priority over a clearing write
    always_ff @(posedge clk) begin
      if (rst)                        isr_q[s] <= 1'b0;
      else if (evt[s])                isr_q[s] <= 1'b1;
      else if (wr_isr && w_bits[s])   isr_q[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= gie_q & (|(ier_q & isr_q));
  end
endmodule

// File: rtl/scd_ctrl_regs.sv
module scd_ctrl_regs
  import scd_ctrl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              eng_start,
  input  logic              eng_done,
  input  logic              eng_ready,
  output logic              flush_req,
  input  logic              flush_drained,
  output logic              irq
);
  logic wr_ctrl, wr_gie, wr_ier, wr_isr, rd_ctrl;
  logic busy, done_q, ready_q, auto_q, fldone_q, done_evt;
  logic gie_q;
  logic [N_SRC-1:0] ier_q, isr_q, src_evt;
  ctrl_view_t ctrl_word;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[DATA_W-1:CTRL_USED], reg_wdata[4]};

  scd_reg_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .ctrl_word (ctrl_word),
    .gie       (gie_q),
    .ier       (ier_q),
    .isr       (isr_q),
    .wr_ctrl   (wr_ctrl),
    .wr_gie    (wr_gie),
    .wr_ier    (wr_ier),
    .wr_isr    (wr_isr),
    .rd_ctrl   (rd_ctrl),
    .rdata     (reg_rdata)
  );

  scd_run_ctrl u_run (
    .clk           (clk),
    .rst           (rst),
    .wr_ctrl       (wr_ctrl),
    .rd_ctrl       (rd_ctrl),
    .w_start       (reg_wdata[CB_START]),
    .w_flreq       (reg_wdata[CB_FLREQ]),
    .w_auto        (reg_wdata[CB_AUTO]),
    .eng_done      (eng_done),
    .eng_ready     (eng_ready),
    .flush_drained (flush_drained),
    .eng_start     (eng_start),
    .busy          (busy),
    .done_q        (done_q),
    .ready_q       (ready_q),
    .auto_q        (auto_q),
    .flreq_q       (flush_req),
    .fldone_q      (fldone_q),
    .done_evt      (done_evt)
  );

  assign src_evt[SRC_DONE]  = done_evt;
  assign src_evt[SRC_READY] = eng_ready;

  scd_irq_unit #(.NS(N_SRC)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .wr_gie (wr_gie),
    .wr_ier (wr_ier),
    .wr_isr (wr_isr),
    .w_gie  (reg_wdata[0]),
    .w_bits (reg_wdata[N_SRC-1:0]),
    .evt    (src_evt),
    .gie_q  (gie_q),
    .ier_q  (ier_q),
    .isr_q  (isr_q),
    .irq    (irq)
  );

  always_comb begin
    ctrl_word         = '0;
    ctrl_word.start   = busy;
    ctrl_word.done    = done_q;
    ctrl_word.idle    = ~busy;
    ctrl_word.ready   = ready_q;
    ctrl_word.fl_req  = flush_req;
    ctrl_word.fl_done = fldone_q;
    ctrl_word.auto_rs = auto_q;
  end
endmodule

// File: rtl/scd_ctrl_regs_chk.sv
module scd_ctrl_regs_chk (
  input logic clk,
  input logic rst,
  input logic eng_done,
  input logic eng_ready,
  input logic eng_start,
  input logic irq,
  input logic flush_req,
  input logic busy,
  input logic auto_q,
  input logic ready_q,
  input logic wr_ctrl,
  input logic w_start,
  input logic gie_q,
  input logic isr_done
);
  // R1: reset leaves outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq && !eng_start && !flush_req));

  // R2: a launch pulse always coincides with a running frame
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> busy);

  // R3: start write while busy yields no launch
  a_r3_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_ctrl && w_start && !eng_done) |=> !eng_start);

  // R4: completion without free-run returns to idle
  a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
    (eng_done && busy && !auto_q) |=> !busy);

  // R5: completion in free-run relaunches
  a_r5_relaunch: assert property (@(posedge clk) disable iff (rst)
    (eng_done && busy && auto_q) |=> (eng_start && busy));

  // R6: ready pulse latches ready bit
  a_r6_ready_set: assert property (@(posedge clk) disable iff (rst)
    eng_ready |=> ready_q);

  // R7: flush request is sticky
  a_r7_flush_sticky: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> flush_req);

  // R8: accepted completion latches status bit 0
  a_r8_isr_set: assert property (@(posedge clk) disable iff (rst)
    (eng_done && busy) |=> isr_done);

  // R9: global gate low keeps irq low
  a_r9_gie_mask: assert property (@(posedge clk) disable iff (rst)
    !gie_q |=> !irq);
endmodule

bind scd_ctrl_regs scd_ctrl_regs_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .eng_done  (eng_done),
  .eng_ready (eng_ready),
  .eng_start (eng_start),
  .irq       (irq),
  .flush_req (flush_req),
  .busy      (busy),
  .auto_q    (auto_q),
  .ready_q   (ready_q),
  .wr_ctrl   (wr_ctrl),
  .w_start   (reg_wdata[0]),
  .gie_q     (gie_q),
  .isr_done  (isr_q[0])
);

// File: tb/scd_ctrl_regs_tb.sv
module scd_ctrl_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic eng_start, flush_req, irq;
  logic eng_done = 1'b0, eng_ready = 1'b0, flush_drained = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int start_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scd_ctrl_regs #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_start(eng_start), .eng_done(eng_done), .eng_ready(eng_ready),
    .flush_req(flush_req), .flush_drained(flush_drained), .irq(irq)
  );

  always @(negedge clk) if (eng_start) start_cnt++;

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic pulse_ready();
    @(negedge clk); eng_ready = 1'b1;
    @(negedge clk); eng_ready = 1'b0;
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(4'h0, v); chk("R1 ctrl", v, 32'h4);
    rd(4'h4, v); chk("R1 gie", v, 0);
    rd(4'h8, v); chk("R1 ier", v, 0);
    rd(4'hC, v); chk("R1 isr", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flush_req", flush_req, 0);
    chk("R1 eng_start count", start_cnt, 0);
  endtask

  task automatic t_reserved();
    logic [DW-1:0] v;
    wr(4'h0, 32'hFFFF_FF10);
    rd(4'h0, v); chk("R10 ctrl reserved", v, 32'h4);
    wr(4'h4, 32'hFFFF_FFFE);
    rd(4'h4, v); chk("R10 gie reserved", v, 0);
    rd(4'h2, v); chk("R10 unmapped", v, 0);
    rd(4'h0, v);
    idle_cycles(3);
    chk("R11 rdata holds", reg_rdata, 32'h4);
  endtask

  task automatic t_start();
    logic [DW-1:0] v;
    int s0 = start_cnt;
    wr(4'h0, 32'h1);
    idle_cycles(1);
    chk("R2 one launch", start_cnt, s0 + 1);
    rd(4'h0, v); chk("R2 busy view", v, 32'h1);
    wr(4'h0, 32'h1);
    idle_cycles(2);
    chk("R3 no launch while busy", start_cnt, s0 + 1);
    pulse_done();
    rd(4'h0, v); chk("R4 done+idle", v, 32'h6);
    rd(4'h0, v); chk("R4 done cleared by read", v, 32'h4);
    wr(4'hC, 32'h3);
    pulse_done();
    rd(4'h0, v); chk("R4 idle done ignored", v, 32'h4);
    rd(4'hC, v); chk("R4 idle done no status", v, 0);
  endtask

  task automatic t_ready();
    logic [DW-1:0] v;
    pulse_ready();
    rd(4'h0, v); chk("R6 ready set", v, 32'hC);
    rd(4'hC, v); chk("R8 ready status", v, 32'h2);
    wr(4'h0, 32'h1);
    rd(4'h0, v); chk("R6 ready cleared by start", v, 32'h1);
    pulse_done();
    rd(4'h0, v);
    wr(4'hC, 32'h3);
  endtask

  task automatic t_auto();
    logic [DW-1:0] v;
    int s0 = start_cnt;
    wr(4'h0, 32'h81);
    rd(4'h0, v); chk("R5 auto readback", v, 32'h81);
    pulse_done();
    idle_cycles(1);
    chk("R5 relaunch", start_cnt, s0 + 2);
    rd(4'h0, v); chk("R5 stays busy", v, 32'h83);
    wr(4'h0, 32'h80);
    pulse_done();
    idle_cycles(1);
    chk("R5 relaunch again", start_cnt, s0 + 3);
    wr(4'h0, 32'h0);
    pulse_done();
    idle_cycles(2);
    chk("R5 stop after clear", start_cnt, s0 + 3);
    rd(4'h0, v); chk("R5 idle after stop", v, 32'h6);
    wr(4'hC, 32'h3);
  endtask

  task automatic t_irq();
    logic [DW-1:0] v;
    wr(4'h8, 32'h1);
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h1);
    pulse_done();
    idle_cycles(2);
    chk("R9 gie masks", irq, 0);
    wr(4'h4, 32'h1);
    idle_cycles(1);
    chk("R9 irq raised", irq, 1);
    wr(4'h8, 32'h2);
    idle_cycles(1);
    chk("R9 source disabled", irq, 0);
    wr(4'h8, 32'h1);
    wr(4'hC, 32'h0);
    idle_cycles(1);
    chk("R8 write 0 keeps", irq, 1);
    wr(4'hC, 32'h1);
    idle_cycles(1);
    chk("R8 write 1 clears irq", irq, 0);
    rd(4'hC, v); chk("R8 status cleared", v, 0);
    // clearing write and new event in the same cycle
    wr(4'h0, 32'h1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'hC; reg_wdata = 32'h1; eng_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; eng_done = 1'b0;
    rd(4'hC, v); chk("R8 event beats clear", v, 32'h1);
    rd(4'h0, v);
    wr(4'hC, 32'h3);
    wr(4'h4, 32'h0);
  endtask

  task automatic t_flush();
    logic [DW-1:0] v;
    flush_drained = 1'b1;
    idle_cycles(2);
    rd(4'h0, v); chk("R7 no flush done without request", v, 32'h4);
    flush_drained = 1'b0;
    wr(4'h0, 32'h20);
    chk("R7 flush_req high", flush_req, 1);
    rd(4'h0, v); chk("R7 not drained yet", v, 32'h24);
    flush_drained = 1'b1;
    idle_cycles(1);
    rd(4'h0, v); chk("R7 flush done", v, 32'h64);
    wr(4'h0, 32'h0);
    chk("R7 flush_req sticky", flush_req, 1);
    rd(4'h0, v); chk("R7 bits sticky", v, 32'h64);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_cycles(4);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_reserved();
    t_start();
    t_ready();
    t_auto();
    t_irq();
    t_flush();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule